// File: doc/BRIEF.md
# Memory Bank Chip-Select Decoder

This block maps bus accesses onto eight independently programmed memory banks. Each bank is described by two 32-bit words, a base word and an option word. They are loaded through a simple write-only configuration port. The base word holds the bank's start address, a machine-select code, a port-width code, a write-protect flag and a valid flag. The option word holds an address mask, which sets the size of the bank's region.

For each access presented on the access port, the block compares the address against every valid bank under that bank's own mask. The lowest-numbered matching bank is chosen. One clock later the block presents a one-hot chip-select, the winning bank's machine code and port-width code, and two error flags. One flag marks a write into a protected bank. The other marks an address that no bank claims. The memory machines, the bus timing and the external pins are handled elsewhere. This block only decides which bank and machine serve the access.

Top module: `bank_select_decoder`

## Requirements
- R1: After reset every bank is invalid, all outputs are zero, and any access reports a no-hit error.
- R2: Configuration word offset 2k writes bank k's base word and offset 2k+1 writes its option word. Base word fields: bits 31:15 start address, bits 12:11 port-width code (1 = 8-bit, 2 = 16-bit, 3 = 32-bit), bit 8 write protect, bits 7:5 machine code, bit 0 valid. Option word bits 31:15 hold the mask. All other bits are ignored.
- R3: A valid bank matches when address bits 31:15 ANDed with the mask equal base bits 31:15 ANDed with the mask. Address bits 14:0 never affect the match.
- R4: A bank whose valid bit is clear never matches, whatever its address and mask.
- R5: When several banks match, only the lowest-numbered one is reported. This holds even when that bank is write protected.
- R6: One cycle after an access, `csOut` carries a single bit at the winning bank's index. `machSel` and `portSize` carry that bank's codes unchanged (machine codes: 0 general-purpose, 1 flash, 4/5/6 programmable machines A/B/C).
- R7: A write whose winning bank is protected asserts no chip-select and sets `wpErr` for one cycle, still reporting the bank's codes. A read of that bank completes normally.
- R8: An access that matches no bank gives `csOut` = 0, zero codes, and `noHitErr` high for exactly that one cycle.
- R9: In a cycle following no access, every output is zero.
- R10: The mask 0xFFFF8000 selects a 32 KB region. The mask 0 makes a bank cover the full 4 GB address space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrAddr | input | 4 | Word offset: bank index times two, plus 1 for the option word |
| cfgWrData | input | 32 | Configuration data |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | 32 | Access address |
| accWrite | input | 1 | Access is a write |
| csOut | output | 8 | One-hot chip-select, registered |
| machSel | output | 3 | Machine code of the winning bank |
| portSize | output | 2 | Port-width code of the winning bank |
| wpErr | output | 1 | Write hit a protected bank |
| noHitErr | output | 1 | Access matched no bank |

## Verification
Addresses are placed just inside and just outside a 1 MB region and a 32 KB region. This separates a correct mask compare from one that ignores the mask, or one that lets the low 15 address bits leak into the match. Overlapping banks (1 MB inside 16 MB, then a 4 GB bank under both) show whether the lowest index wins. The same address is tried before and after a bank is invalidated and after protection is turned on. Each such address is tried as both a read and a write, which separates the valid-bit and write-protect rules from the plain match.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  localparam int ADDR_W   = 32;
  localparam int MASK_LSB = 15;
  localparam int TAG_W    = ADDR_W - MASK_LSB;

  typedef struct packed {
    logic [TAG_W-1:0] baseTag;
    logic [1:0]       portSize;
    logic             wrProt;
    logic [2:0]       mach;
    logic             valid;
  } bankCfg_t;

  typedef struct packed {
    logic baseWe;
    logic optWe;
    logic capture;
    logic isWrite;
  } ctrlStrobe_t;
endpackage

// File: rtl/bank_dec_ctrl.sv
module bank_dec_ctrl
  import bank_dec_pkg::*;
(
  input  logic        cfgWrEn,
  input  logic        wordSel,
  input  logic        accValid,
  input  logic        accWrite,
  output ctrlStrobe_t strobe
);
  always_comb begin
    strobe.baseWe  = cfgWrEn && !wordSel;
    strobe.optWe   = cfgWrEn && wordSel;
    strobe.capture = accValid;
    strobe.isWrite = accValid && accWrite;
  end
endmodule

// File: rtl/bank_dec_path.sv
module bank_dec_path
  import bank_dec_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int IDX_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobe_t          strobe,
  input  logic [IDX_W-1:0]     cfgBank,
  input  logic [ADDR_W-1:0]    cfgWrData,
  input  logic [ADDR_W-1:0]    accAddr,
  output logic [NUM_BANKS-1:0] csOut,
  output logic [2:0]           machSel,
  output logic [1:0]           portSize,
  output logic                 wpErr,
  output logic                 noHitErr
);
  bankCfg_t             cfg  [NUM_BANKS];
  logic [TAG_W-1:0]     mask [NUM_BANKS];
  logic [NUM_BANKS-1:0] hitVec;
  logic [TAG_W-1:0]     accTag;

  assign accTag = accAddr[ADDR_W-1:MASK_LSB];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[b]  <= '0;
        mask[b] <= '0;
      end else if (cfgBank == IDX_W'(b)) begin
        if (strobe.baseWe) begin
          cfg[b].baseTag  <= cfgWrData[ADDR_W-1:MASK_LSB];
          cfg[b].portSize <= cfgWrData[12:11];
          cfg[b].wrProt   <= cfgWrData[8];
          cfg[b].mach     <= cfgWrData[7:5];
          cfg[b].valid    <= cfgWrData[0];
        end
        if (strobe.optWe) mask[b] <= cfgWrData[ADDR_W-1:MASK_LSB];
      end
    end
    assign hitVec[b] = cfg[b].valid &&
                       ((accTag & mask[b]) == (cfg[b].baseTag & mask[b]));
  end

  logic                 anyHit;
  logic [IDX_W-1:0]     winIdx;
  logic [NUM_BANKS-1:0] winOneHot;

  always_comb begin
    anyHit    = 1'b0;
    winIdx    = '0;
    winOneHot = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (hitVec[b]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(b);
      end
    end
    if (anyHit) winOneHot[winIdx] = 1'b1;
  end

  logic blocked;
  assign blocked = anyHit && strobe.isWrite && cfg[winIdx].wrProt;

  always_ff @(posedge clk) begin
    if (!rst_n || !strobe.capture) begin
      csOut    <= '0;
      machSel  <= '0;
      portSize <= '0;
      wpErr    <= 1'b0;
      noHitErr <= 1'b0;
    end else begin
      csOut    <= blocked ? '0 : winOneHot;
      machSel  <= anyHit ? cfg[winIdx].mach : 3'd0;
      portSize <= anyHit ? cfg[winIdx].portSize : 2'd0;
      wpErr    <= blocked;
      noHitErr <= !anyHit;
    end
  end
endmodule

// File: rtl/bank_select_decoder.sv
module bank_select_decoder
  import bank_dec_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int IDX_W     = $clog2(NUM_BANKS),
  parameter int CFG_AW    = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfgWrEn,
  input  logic [CFG_AW-1:0]    cfgWrAddr,
  input  logic [31:0]          cfgWrData,
  input  logic                 accValid,
  input  logic [31:0]          accAddr,
  input  logic                 accWrite,
  output logic [NUM_BANKS-1:0] csOut,
  output logic [2:0]           machSel,
  output logic [1:0]           portSize,
  output logic                 wpErr,
  output logic                 noHitErr
);
  ctrlStrobe_t strobe;

  bank_dec_ctrl i_ctrl (
    .cfgWrEn (cfgWrEn),
    .wordSel (cfgWrAddr[0]),
    .accValid(accValid),
    .accWrite(accWrite),
    .strobe  (strobe)
  );

  bank_dec_path #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) i_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .cfgBank  (cfgWrAddr[CFG_AW-1:1]),
    .cfgWrData(cfgWrData),
    .accAddr  (accAddr),
    .csOut    (csOut),
    .machSel  (machSel),
    .portSize (portSize),
    .wpErr    (wpErr),
    .noHitErr (noHitErr)
  );
endmodule

// File: rtl/bank_dec_chk.sv
module bank_dec_chk #(
  parameter int NUM_BANKS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 accValid,
  input logic                 accWrite,
  input logic [NUM_BANKS-1:0] csOut,
  input logic [2:0]           machSel,
  input logic [1:0]           portSize,
  input logic                 wpErr,
  input logic                 noHitErr
);
  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(csOut));

  // R8
  nohit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    noHitErr |-> (csOut == '0) && !wpErr && (machSel == 3'd0) && (portSize == 2'd0));

  // R7
  wp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wpErr |-> $past(accValid) && $past(accWrite) && (csOut == '0));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accValid) |-> (csOut == '0) && !wpErr && !noHitErr && (machSel == 3'd0));

  // R8
  access_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accValid) |-> $countones({|csOut, wpErr, noHitErr}) == 1);
endmodule

bind bank_select_decoder bank_dec_chk #(.NUM_BANKS(NUM_BANKS)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .accValid(accValid),
  .accWrite(accWrite),
  .csOut   (csOut),
  .machSel (machSel),
  .portSize(portSize),
  .wpErr   (wpErr),
  .noHitErr(noHitErr)
);

// File: tb/test_bank_select_decoder.sv
`timescale 1ns/1ps
module test_bank_select_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgWrAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accWrite = 1'b0;
  logic [7:0]  csOut;
  logic [2:0]  machSel;
  logic [1:0]  portSize;
  logic        wpErr;
  logic        noHitErr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bank_select_decoder i_bank_select_decoder (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .accValid(accValid), .accAddr(accAddr),
    .accWrite(accWrite), .csOut(csOut), .machSel(machSel),
    .portSize(portSize), .wpErr(wpErr), .noHitErr(noHitErr)
  );

  function automatic logic [31:0] mkBase(logic [31:0] a, logic [1:0] ps,
                                         logic wp, logic [2:0] m, logic v);
    return (a & 32'hFFFF_8000) | (32'(ps) << 11) | (32'(wp) << 8) |
           (32'(m) << 5) | 32'(v);
  endfunction

  task automatic wrCfg(int bank, bit opt, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = 4'(bank * 2 + int'(opt)); cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic compare(string req, logic [7:0] eCs, logic [2:0] eM,
                         logic [1:0] eP, logic eWp, logic eNh);
    checks++;
    if (csOut !== eCs || machSel !== eM || portSize !== eP ||
        wpErr !== eWp || noHitErr !== eNh) begin
      errors++;
      $display("FAIL %s: got cs=%h m=%0d ps=%0d wp=%b nh=%b exp cs=%h m=%0d ps=%0d wp=%b nh=%b",
               req, csOut, machSel, portSize, wpErr, noHitErr,
               eCs, eM, eP, eWp, eNh);
    end
  endtask

  task automatic probe(string req, logic [31:0] a, logic wr, logic [7:0] eCs,
                       logic [2:0] eM, logic [1:0] eP, logic eWp, logic eNh);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accWrite = wr;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0;
    compare(req, eCs, eM, eP, eWp, eNh);
  endtask

  task automatic idleCheck(string req);
    @(negedge clk);
    compare(req, 8'h00, 3'd0, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic tReset();
    compare("R1 reset outputs", 8'h00, 3'd0, 2'd0, 1'b0, 1'b0);
    probe("R1 unprogrammed access", 32'h0000_0000, 1'b0, 8'h00, 3'd0, 2'd0, 1'b0, 1'b1);
    probe("R1 unprogrammed high", 32'hFFFF_FFFC, 1'b1, 8'h00, 3'd0, 2'd0, 1'b0, 1'b1);
  endtask

  task automatic tBasic();
    wrCfg(2, 1'b0, mkBase(32'h4000_0000, 2'd3, 1'b0, 3'd0, 1'b1) | 32'h0000_6000);
    wrCfg(2, 1'b1, 32'hFFF0_0000 | 32'h0000_7FFF);
    probe("R3 R6 inside 1MB", 32'h4001_2344, 1'b0, 8'h04, 3'd0, 2'd3, 1'b0, 1'b0);
    probe("R3 top of 1MB", 32'h400F_FFFF, 1'b1, 8'h04, 3'd0, 2'd3, 1'b0, 1'b0);
    probe("R8 just past 1MB", 32'h4010_0000, 1'b0, 8'h00, 3'd0, 2'd0, 1'b0, 1'b1);
    idleCheck("R8 R9 nohit one cycle");
  endtask

  task automatic tPriority();
    wrCfg(5, 1'b0, mkBase(32'h4000_0000, 2'd1, 1'b0, 3'd5, 1'b1));
    wrCfg(5, 1'b1, 32'hFF00_0000);
    probe("R5 overlap lower wins", 32'h4000_0010, 1'b0, 8'h04, 3'd0, 2'd3, 1'b0, 1'b0);
    probe("R2 R6 bank5 only", 32'h4080_0000, 1'b0, 8'h20, 3'd5, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic tValid();
    wrCfg(2, 1'b0, mkBase(32'h4000_0000, 2'd3, 1'b0, 3'd0, 1'b0));
    probe("R4 invalid bank skipped", 32'h4000_0010, 1'b0, 8'h20, 3'd5, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic tProtect();
    wrCfg(5, 1'b0, mkBase(32'h4000_0000, 2'd1, 1'b1, 3'd5, 1'b1));
    probe("R7 read protected ok", 32'h4000_0010, 1'b0, 8'h20, 3'd5, 2'd1, 1'b0, 1'b0);
    probe("R7 write protected", 32'h4000_0010, 1'b1, 8'h00, 3'd5, 2'd1, 1'b1, 1'b0);
    idleCheck("R7 R9 wp one cycle");
    probe("R8 write miss", 32'h1234_0000, 1'b1, 8'h00, 3'd0, 2'd0, 1'b0, 1'b1);
  endtask

  task automatic tMinRegion();
    wrCfg(0, 1'b0, mkBase(32'h1000_8000, 2'd2, 1'b0, 3'd1, 1'b1));
    wrCfg(0, 1'b1, 32'hFFFF_8000);
    probe("R10 32KB inside", 32'h1000_FFFC, 1'b1, 8'h01, 3'd1, 2'd2, 1'b0, 1'b0);
    probe("R10 32KB above", 32'h1001_0000, 1'b0, 8'h00, 3'd0, 2'd0, 1'b0, 1'b1);
    probe("R10 32KB below", 32'h1000_7FFC, 1'b0, 8'h00, 3'd0, 2'd0, 1'b0, 1'b1);
  endtask

  task automatic tFullSpace();
    wrCfg(7, 1'b0, mkBase(32'hABCD_8000, 2'd3, 1'b0, 3'd6, 1'b1));
    wrCfg(7, 1'b1, 32'h0000_0000);
    probe("R10 4GB bank", 32'hFFFF_FFFC, 1'b0, 8'h80, 3'd6, 2'd3, 1'b0, 1'b0);
    probe("R5 bank0 over 4GB", 32'h1000_8000, 1'b0, 8'h01, 3'd1, 2'd2, 1'b0, 1'b0);
    probe("R5 protected lower wins", 32'h4000_0010, 1'b1, 8'h00, 3'd5, 2'd1, 1'b1, 1'b0);
    probe("R10 4GB catches miss", 32'h1234_0000, 1'b1, 8'h80, 3'd6, 2'd3, 1'b0, 1'b0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tReset();
    tBasic();
    tPriority();
    tValid();
    tProtect();
    tMinRegion();
    tFullSpace();
    idleCheck("R9 final idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule